// File: doc/BRIEF.md
# OLED Window Scanout Pixel Generator

This block turns a page-organised monochrome frame memory into a raster pixel stream for a small display window. The memory holds 132 columns by 8 pages of bytes; each byte carries eight vertically stacked pixels, one per bit, so a memory line is one bit position across a page. The block shows a 96 by 16 window starting at column 36, and it begins that window at a programmable memory line that wraps modulo 64.

Each frame is started by a one-cycle start request, and only when a pending-redraw flag is set. The flag is raised by a mark input and dropped once the last pixel of a frame has been produced. During a frame the block issues one memory read per cycle on a synchronous read port with one cycle of latency and emits one pixel per cycle with its x and y coordinates. Two display modes are applied on the way out: all-lit forces every pixel on, and invert swaps lit and unlit pixels. The start line and both modes are captured when a frame is accepted.

Top module: `oled_scanout`

## Requirements
- R1: After reset, pix_valid_o, mem_rd_o, frame_done_o, busy_o and dirty_o are all 0.
- R2: An accepted frame produces exactly 1536 pixels on consecutive cycles in raster order: x from 0 to 95 fastest, then y from 0 to 15.
- R3: For visible pixel (x, y) the block reads address 132*(line/8) + 36 + x with line = (y + start line) mod 64, and presents that pixel with pix_valid_o exactly one cycle after the read.
- R4: With both modes clear, pix_o equals bit (line mod 8) of the byte returned on mem_data_i, bit 0 being the least significant.
- R5: With invert set and all-lit clear, pix_o is the complement of that bit.
- R6: With all-lit set, pix_o is 1 for every pixel, whatever the memory data and the invert setting.
- R7: start_line_i, all_on_i and invert_i are sampled on the cycle a start is accepted; changes during a frame have no effect on its addresses or pixels.
- R8: A start request while the redraw flag (dirty_o) is 0 is ignored: no read and no pixel follow it.
- R9: frame_done_o is 1 for exactly one cycle, the cycle after the last pixel (x=95, y=15); in that cycle dirty_o is 0 unless mark_i was 1 on the last-pixel cycle, in which case it stays 1.
- R10: A start request while busy_o is 1 is ignored: the running frame continues unchanged and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Frame start request, one cycle |
| mark_i | input | 1 | Sets the pending-redraw flag |
| start_line_i | input | 6 | First memory line shown on visible row 0 |
| all_on_i | input | 1 | All-lit mode |
| invert_i | input | 1 | Invert mode |
| mem_rd_o | output | 1 | Frame memory read strobe |
| mem_addr_o | output | 11 | Frame memory byte address |
| mem_data_i | input | 8 | Read data, one cycle after the strobe |
| pix_valid_o | output | 1 | Pixel output valid |
| pix_o | output | 1 | Pixel value, 1 = lit |
| pix_x_o | output | 7 | Pixel column 0..95 |
| pix_y_o | output | 4 | Pixel row 0..15 |
| frame_done_o | output | 1 | One-cycle pulse after the last pixel |
| busy_o | output | 1 | Frame reads or pixels in flight |
| dirty_o | output | 1 | Pending-redraw flag |

## Verification
Assertions watch on every cycle that reads stay inside the memory, that the read stream and the x sequence advance without gaps, that the done pulse never lasts two cycles, that a start arriving while busy leaves the captured settings alone, and that a frame only begins after the redraw flag was set. The exact addresses, the bit chosen from each byte, the effect of each mode, wrap-around of the start line and the handling of the flag when a new mark meets the end of a frame are shown only by the bench's frames, which compare every pixel with a bench model of the memory.

// File: rtl/oled_scan_pkg.sv
// Shared types for the OLED window scanout.
// Assumes: one monochrome bit per pixel, 1 meaning lit.
package oled_scan_pkg;

    // Display mode captured at frame start.
    typedef struct packed {
        logic all_on;
        logic invert;
    } scan_mode_t;

    // Maps a stored bit to the shown pixel; all-lit overrides invert.
    function automatic logic scan_pixel_value(input scan_mode_t m, input logic stored);
        return m.all_on | (stored ^ m.invert);
    endfunction

endpackage

// File: rtl/oled_scan_ctrl.sv
// Frame control: redraw flag, start acceptance and capture of settings.
// Assumes: last_fetch_i pulses on the final read of a frame, last_pix_i on the
// final pixel; pipe_busy_i is high while a read result is still in flight.
module oled_scan_ctrl
    import oled_scan_pkg::*;
#(
    parameter int LW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mark_i,
    input  logic [LW-1:0] start_line_i,
    input  scan_mode_t    mode_i,
    input  logic          last_fetch_i,
    input  logic          last_pix_i,
    input  logic          pipe_busy_i,
    output logic          active_o,
    output logic          accept_o,
    output logic [LW-1:0] line_ofs_o,
    output scan_mode_t    mode_o,
    output logic          busy_o,
    output logic          dirty_o
);

    logic          active_q;
    logic          dirty_q;
    logic [LW-1:0] ofs_q;
    scan_mode_t    mode_q;

    // Busy covers the read phase and the one-cycle read latency.
    assign busy_o   = active_q | pipe_busy_i;
    // A start only counts when idle and a redraw is pending.
    assign accept_o = start_i & dirty_q & ~busy_o;

    // Read-phase flag and settings capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            ofs_q    <= '0;
            mode_q   <= '0;
        end else if (accept_o) begin
            active_q <= 1'b1;
            ofs_q    <= start_line_i;
            mode_q   <= mode_i;
        end else if (last_fetch_i) begin
            active_q <= 1'b0;
        end
    end

    // Redraw flag: a mark wins over the end-of-frame clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          dirty_q <= 1'b0;
        else if (mark_i)     dirty_q <= 1'b1;
        else if (last_pix_i) dirty_q <= 1'b0;
    end

    assign active_o   = active_q;
    assign line_ofs_o = ofs_q;
    assign mode_o     = mode_q;
    assign dirty_o    = dirty_q;

    // R10: a start during a frame leaves the captured settings alone.
    assert_start_busy_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(ofs_q) && $stable(mode_q)));

    // R8: a frame only begins when the redraw flag was set.
    assert_frame_needs_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_q) |-> $past(dirty_q));

endmodule

// File: rtl/oled_scan_fetch.sv
// Read address generator: walks the visible window in raster order and
// turns each (x, y) into a page/column byte address plus a bit select.
// Assumes: start line wraps modulo the number of memory lines.
module oled_scan_fetch #(
    parameter int VIS_W    = 96,
    parameter int VIS_H    = 16,
    parameter int MEM_COLS = 132,
    parameter int COL_OFS  = 36,
    parameter int LW       = 6,
    parameter int AW       = 11,
    parameter int XW       = 7,
    parameter int YW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_i,
    input  logic          active_i,
    input  logic [LW-1:0] line_ofs_i,
    output logic          rd_o,
    output logic [AW-1:0] addr_o,
    output logic [XW-1:0] x_o,
    output logic [YW-1:0] y_o,
    output logic [2:0]    bit_o,
    output logic          last_o
);

    localparam logic [XW-1:0] X_MAX = XW'(VIS_W - 1);
    localparam logic [YW-1:0] Y_MAX = YW'(VIS_H - 1);
    localparam int            TOTAL = MEM_COLS * (1 << (LW - 3));

    logic [XW-1:0] x_q;
    logic [YW-1:0] y_q;
    logic [LW-1:0] line;

    // Raster counters, x fastest, cleared at frame acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n || accept_i) begin
            x_q <= '0;
            y_q <= '0;
        end else if (active_i) begin
            if (x_q == X_MAX) begin
                x_q <= '0;
                y_q <= y_q + YW'(1);
            end else begin
                x_q <= x_q + XW'(1);
            end
        end
    end

    // Memory line wraps naturally in LW bits.
    assign line   = LW'(y_q) + line_ofs_i;
    assign addr_o = AW'(line[LW-1:3]) * AW'(MEM_COLS) + AW'(COL_OFS) + AW'(x_q);
    assign bit_o  = line[2:0];
    assign rd_o   = active_i;
    assign x_o    = x_q;
    assign y_o    = y_q;
    assign last_o = active_i && (x_q == X_MAX) && (y_q == Y_MAX);

    // R3: every read lands inside the frame memory.
    assert_addr_in_memory_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o |-> (int'(addr_o) < TOTAL));

    // R2: the read stream has no gaps until the last read.
    assert_reads_back_to_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_o && !last_o) |=> rd_o);

endmodule

// File: rtl/oled_scan_pixel.sv
// Pixel stage: aligns coordinates with the one-cycle read latency, picks the
// bit out of the returned byte, applies the display mode, flags frame end.
// Assumes: mem_data_i belongs to the read issued on the previous cycle.
module oled_scan_pixel
    import oled_scan_pkg::*;
#(
    parameter int VIS_W = 96,
    parameter int VIS_H = 16,
    parameter int XW    = 7,
    parameter int YW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_i,
    input  logic [XW-1:0] x_i,
    input  logic [YW-1:0] y_i,
    input  logic [2:0]    bit_i,
    input  scan_mode_t    mode_i,
    input  logic [7:0]    mem_data_i,
    output logic          valid_o,
    output logic          pix_o,
    output logic [XW-1:0] x_o,
    output logic [YW-1:0] y_o,
    output logic          last_o,
    output logic          done_o
);

    localparam logic [XW-1:0] X_MAX = XW'(VIS_W - 1);
    localparam logic [YW-1:0] Y_MAX = YW'(VIS_H - 1);

    logic          rd_q;
    logic [XW-1:0] x_q;
    logic [YW-1:0] y_q;
    logic [2:0]    bit_q;
    logic          done_q;

    // Delay line matching the memory read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= 1'b0;
            x_q   <= '0;
            y_q   <= '0;
            bit_q <= '0;
        end else begin
            rd_q  <= rd_i;
            x_q   <= x_i;
            y_q   <= y_i;
            bit_q <= bit_i;
        end
    end

    assign last_o = rd_q && (x_q == X_MAX) && (y_q == Y_MAX);

    // Done pulse on the cycle after the last pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= last_o;
    end

    assign valid_o = rd_q;
    assign pix_o   = scan_pixel_value(mode_i, mem_data_i[bit_q]);
    assign x_o     = x_q;
    assign y_o     = y_q;
    assign done_o  = done_q;

    // R2: within a line, x steps by one on the next cycle.
    assert_x_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q && x_q != X_MAX) |=> (rd_q && x_q == $past(x_q) + XW'(1)));

    // R9: the done pulse lasts a single cycle.
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/oled_scanout.sv
// OLED window scanout top: ties frame control, address generation and the
// pixel stage together. One pixel per cycle while a frame runs.
// Assumes: frame memory has a synchronous read port with one cycle latency.
module oled_scanout
    import oled_scan_pkg::*;
#(
    parameter int VIS_W     = 96,
    parameter int VIS_H     = 16,
    parameter int MEM_COLS  = 132,
    parameter int MEM_PAGES = 8,
    parameter int COL_OFS   = 36,
    localparam int LW = $clog2(MEM_PAGES * 8),
    localparam int AW = $clog2(MEM_COLS * MEM_PAGES),
    localparam int XW = $clog2(VIS_W),
    localparam int YW = $clog2(VIS_H)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mark_i,
    input  logic [LW-1:0] start_line_i,
    input  logic          all_on_i,
    input  logic          invert_i,
    output logic          mem_rd_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic [7:0]    mem_data_i,
    output logic          pix_valid_o,
    output logic          pix_o,
    output logic [XW-1:0] pix_x_o,
    output logic [YW-1:0] pix_y_o,
    output logic          frame_done_o,
    output logic          busy_o,
    output logic          dirty_o
);

    scan_mode_t    mode_in, mode_q;
    logic          active, accept, last_fetch, last_pix;
    logic [LW-1:0] line_ofs;
    logic [XW-1:0] fx;
    logic [YW-1:0] fy;
    logic [2:0]    fbit;

    // Bundle the mode inputs.
    always_comb begin
        mode_in.all_on = all_on_i;
        mode_in.invert = invert_i;
    end

    oled_scan_ctrl #(.LW(LW)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mark_i       (mark_i),
        .start_line_i (start_line_i),
        .mode_i       (mode_in),
        .last_fetch_i (last_fetch),
        .last_pix_i   (last_pix),
        .pipe_busy_i  (pix_valid_o),
        .active_o     (active),
        .accept_o     (accept),
        .line_ofs_o   (line_ofs),
        .mode_o       (mode_q),
        .busy_o       (busy_o),
        .dirty_o      (dirty_o)
    );

    oled_scan_fetch #(
        .VIS_W(VIS_W), .VIS_H(VIS_H), .MEM_COLS(MEM_COLS), .COL_OFS(COL_OFS),
        .LW(LW), .AW(AW), .XW(XW), .YW(YW)
    ) fetch_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .active_i   (active),
        .line_ofs_i (line_ofs),
        .rd_o       (mem_rd_o),
        .addr_o     (mem_addr_o),
        .x_o        (fx),
        .y_o        (fy),
        .bit_o      (fbit),
        .last_o     (last_fetch)
    );

    oled_scan_pixel #(
        .VIS_W(VIS_W), .VIS_H(VIS_H), .XW(XW), .YW(YW)
    ) pixel_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (mem_rd_o),
        .x_i        (fx),
        .y_i        (fy),
        .bit_i      (fbit),
        .mode_i     (mode_q),
        .mem_data_i (mem_data_i),
        .valid_o    (pix_valid_o),
        .pix_o      (pix_o),
        .x_o        (pix_x_o),
        .y_o        (pix_y_o),
        .last_o     (last_pix),
        .done_o     (frame_done_o)
    );

endmodule

// File: tb/oled_scanout_tb.sv
// Bench for oled_scanout: random memory image and frame settings with a
// fixed seed, plus directed cases (start-line wrap, modes, ignored starts).
module oled_scanout_tb_top;

    localparam int NBYTES = 1056;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, mark_i = 1'b0;
    logic [5:0]  start_line_i = '0;
    logic        all_on_i = 1'b0, invert_i = 1'b0;
    logic        mem_rd_o;
    logic [10:0] mem_addr_o;
    logic [7:0]  mem_data_i = '0;
    logic        pix_valid_o, pix_o, frame_done_o, busy_o, dirty_o;
    logic [6:0]  pix_x_o;
    logic [3:0]  pix_y_o;

    oled_scanout dut_i (.*);

    always #4 clk = ~clk;   // 125 MHz

    logic [7:0] mem [NBYTES];

    // Memory model: synchronous read, one cycle latency.
    always @(posedge clk) if (mem_rd_o && mem_addr_o < 11'(NBYTES)) mem_data_i <= mem[mem_addr_o];

    int checks = 0, failures = 0, cyc = 0;
    bit ended = 0;

    // Frame expectations and observations.
    int e_sl; bit e_inv, e_ent;
    int fx, fy, ex, ey, n_rd, n_pix, n_done;
    int err_addr, err_ord, err_pix;
    bit prev_last, done_bad;

    function automatic int exp_line(int y, int sl);
        return (y + sl) & 63;
    endfunction
    function automatic int exp_addr(int x, int y, int sl);
        return 132 * (exp_line(y, sl) >> 3) + 36 + x;
    endfunction
    function automatic bit exp_pix(int x, int y, int sl, bit inv, bit ent);
        bit b;
        b = mem[exp_addr(x, y, sl)][exp_line(y, sl) & 7];
        return ent ? 1'b1 : (b ^ inv);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_obs();
        fx = 0; fy = 0; ex = 0; ey = 0; n_rd = 0; n_pix = 0; n_done = 0;
        err_addr = 0; err_ord = 0; err_pix = 0; done_bad = 0;
    endtask

    // Monitor, sampling away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd_o) begin
                if (int'(mem_addr_o) != exp_addr(fx, fy, e_sl)) err_addr++;
                n_rd++;
                if (fx == 95) begin fx = 0; fy++; end else fx++;
            end
            if (pix_valid_o) begin
                if (int'(pix_x_o) != ex || int'(pix_y_o) != ey) err_ord++;
                else if (pix_o !== exp_pix(ex, ey, e_sl, e_inv, e_ent)) err_pix++;
                n_pix++;
                if (ex == 95) begin ex = 0; ey++; end else ex++;
            end
            if (frame_done_o) begin
                n_done++;
                if (!prev_last) done_bad = 1;
            end
            prev_last = pix_valid_o && pix_x_o == 7'd95 && pix_y_o == 4'd15;
        end
    end

    task automatic pulse_start();
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    endtask
    task automatic pulse_mark();
        mark_i = 1'b1; @(negedge clk); mark_i = 1'b0;
    endtask

    // One frame with given settings; optional mid-frame disturbance and
    // a mark coinciding with the last pixel.
    task automatic run_frame(int sl, bit inv, bit ent, bit disturb, bit mark_end, string mreq);
        int wait_cyc;
        start_line_i = 6'(sl); invert_i = inv; all_on_i = ent;
        e_sl = sl; e_inv = inv; e_ent = ent;
        pulse_mark();
        clear_obs();
        pulse_start();
        if (disturb) begin
            repeat (300) @(negedge clk);
            // R7 / R10: change settings and request a start mid-frame.
            start_line_i = 6'($urandom_range(0, 63));
            invert_i = ~inv; all_on_i = ~ent;
            pulse_start();
        end
        if (mark_end) begin
            wait_cyc = 0;
            while (!(pix_valid_o && pix_x_o == 7'd95 && pix_y_o == 4'd15) && wait_cyc < 4000) begin
                @(negedge clk); wait_cyc++;
            end
            mark_i = 1'b1; @(negedge clk); mark_i = 1'b0;
            check(frame_done_o && dirty_o, "R9", "mark on last pixel keeps dirty", int'(dirty_o), 1);
        end
        wait_cyc = 0;
        while (n_done == 0 && wait_cyc < 4000) begin @(negedge clk); wait_cyc++; end
        repeat (4) @(negedge clk);
        check(n_pix == 1536, "R2", "pixel count", n_pix, 1536);
        check(err_ord == 0, "R2", "raster order errors", err_ord, 0);
        check(err_addr == 0 && n_rd == 1536, "R3", "address errors", err_addr, 0);
        check(err_pix == 0, mreq, "pixel value errors", err_pix, 0);
        check(n_done == 1 && !done_bad, "R9", "done pulses", n_done, 1);
        if (!mark_end) check(dirty_o == 1'b0, "R9", "dirty after frame", int'(dirty_o), 0);
        if (disturb) check(n_pix == 1536 && n_done == 1, "R10", "start while busy ignored", n_pix, 1536);
        if (disturb) check(err_addr == 0 && err_pix == 0, "R7", "settings held mid-frame", err_addr + err_pix, 0);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            ended = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        for (int i = 0; i < NBYTES; i++) mem[i] = 8'($urandom);
        e_sl = 0; e_inv = 0; e_ent = 0; prev_last = 0;
        clear_obs();
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(!pix_valid_o && !mem_rd_o && !frame_done_o && !busy_o && !dirty_o,
              "R1", "outputs in reset", int'({pix_valid_o, mem_rd_o, frame_done_o, busy_o, dirty_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !dirty_o, "R1", "idle after reset", int'({busy_o, dirty_o}), 0);

        // R8: start with no pending redraw is ignored.
        clear_obs();
        pulse_start();
        repeat (20) @(negedge clk);
        check(n_rd == 0 && n_pix == 0 && !busy_o, "R8", "start without dirty", n_rd + n_pix, 0);

        // Directed frames.
        run_frame(0,  1'b0, 1'b0, 1'b0, 1'b0, "R4");
        run_frame(60, 1'b0, 1'b0, 1'b0, 1'b0, "R4");   // start line wraps
        run_frame(63, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
        run_frame(17, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
        run_frame(9,  1'b0, 1'b0, 1'b1, 1'b0, "R4");   // disturbed mid-frame
        run_frame(33, 1'b0, 1'b1, 1'b0, 1'b1, "R6");   // mark on last pixel

        // After that frame dirty stayed set; a new start is accepted.
        check(dirty_o == 1'b1, "R9", "dirty kept by late mark", int'(dirty_o), 1);

        // Random frames.
        for (int k = 0; k < 5; k++) begin
            int sl; bit inv, ent;
            sl = $urandom_range(0, 63); inv = 1'($urandom); ent = 1'($urandom);
            run_frame(sl, inv, ent, 1'($urandom), 1'b0, ent ? "R6" : (inv ? "R5" : "R4"));
        end

        // R8: flag now clear, start ignored again.
        clear_obs();
        pulse_start();
        repeat (20) @(negedge clk);
        check(n_rd == 0 && n_pix == 0, "R8", "start after clear ignored", n_rd + n_pix, 0);

        ended = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule